// File: doc/BRIEF.md
# SMBus Indexed Block Configuration Register Target

This block is an SMBus target that holds a bank of eight configuration bytes for a small clock-distribution device. The open-drain SCL and SDA lines are brought in on the system clock through synchronizers. The block pulls SDA low only to acknowledge and to send data. Every transfer names a starting register index. A write then gives an explicit byte count followed by the data. A read uses a repeated start and returns a count byte first, then the register contents.

The register bank drives the device controls directly. It provides two output enables gated by a hardware enable pin, per-output edge-rate selects, an amplitude code, and mode and frequency-select fields. The mode and frequency-select fields are honoured only when their own enable bits are set. When the mode enable is clear, the mode comes from pins sampled once after reset. That sampled value can also be read back over the bus.

Top module: `cfg_smbus_target`

## Requirements
- R1: The target answers only the 7-bit address 1101101 (byte 0xDA to write, 0xDB to read). Any other address gets no acknowledge, and the block ignores the bus until the next start.
- R2: An indexed write (address+W, index N, count X, then data) acknowledges every byte and stores data into registers N, N+1, … N+X-1. The index advances after each stored byte.
- R3: Data bytes beyond the count X are acknowledged and discarded.
- R4: An indexed read (address+W, index N, repeated start, address+R) first sends a count byte equal to register 7, then registers N, N+1, … for as long as the host acknowledges. After a host NACK, SDA is released.
- R5: Register 7 bits [4:0] are writable. Its bits [7:5] read 0, and it resets to 0x08.
- R6: Reset read values: reg0 0xFF, reg1 {pins,6'b000110}, reg2 0xFF, reg3 0xC7. Register 4 and any index above 7 read 0xFF. Reserved bits in registers 0–3 read 1.
- R7: Register 5 reads 0x01 and register 6 reads 0x42. Writes to read-only bits, to registers 4–6 or to any index above 7 are acknowledged and have no effect.
- R8: out_en_o[0] = hw_oe_i AND reg0 bit 3, and out_en_o[1] = hw_oe_i AND reg0 bit 5.
- R9: reg1 bits [7:6] hold mode_pins_i as sampled in the first cycle after reset. mode_o = reg1[4:3] when reg1 bit 5 is 1, otherwise the sampled pins.
- R10: freq_o = reg3[4:3] when reg3 bit 5 is 1, otherwise 00. amp_o = reg1[1:0]. slew_fast_o = {reg2 bit 5, reg2 bit 3}. fb_slew_fast_o = reg3 bit 0.
- R11: A start seen at any point, including partway through a byte, aborts the current transfer without a write and begins a new address phase.
- R12: sda_oe_o is 0 whenever the bus is idle between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| hw_oe_i | input | 1 | Hardware output-enable pin, active high |
| mode_pins_i | input | 2 | Mode strap pins, sampled after reset |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| out_en_o | output | 2 | Effective output enables |
| slew_fast_o | output | 2 | Per-output fast edge-rate select |
| fb_slew_fast_o | output | 1 | Feedback edge-rate select |
| amp_o | output | 2 | Amplitude code |
| mode_o | output | 2 | Effective operating mode |
| freq_o | output | 2 | Effective frequency select |

## Verification
Writes are tried with an exact count, with extra bytes past the count, and with a span that covers read-only and non-existent indices. These separate storage, the count limit and the write masks. Reads start at index 0, in the middle of the bank and past its end. They compare the count byte and every returned byte, which exposes both the auto-increment and the fill value for unmapped indices. A foreign address, a start inside a data byte and a new reset with different strap pins check the address filter, the abort path and the strap sampling. Between transfers, every output is compared on every clock with a behavioural model, with the hardware enable pin both high and low.

// File: rtl/cfg_smbus_pkg.sv
package cfg_smbus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_OFFS, ST_CNT, ST_WDATA,
    ST_ACK, ST_TX, ST_HACK, ST_WAIT
  } tgt_state_e;

  localparam int unsigned MODE_IDX = 1;
  localparam int unsigned CNT_IDX  = 7;

  // Writable bits of each register.
  function automatic logic [7:0] reg_wmask(input int unsigned idx);
    case (idx)
      0, 2:    return 8'h28;
      1:       return 8'h3B;
      3:       return 8'h39;
      7:       return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  // Value of the non-writable bits.
  function automatic logic [7:0] reg_fixed(input int unsigned idx);
    case (idx)
      1:       return 8'hC4;
      5:       return 8'h01;
      6:       return 8'h42;
      7:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reg_rstval(input int unsigned idx);
    case (idx)
      0, 2:    return 8'h28;
      1:       return 8'h02;
      3:       return 8'h01;
      7:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda       = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_prev;
  assign scl_fall  = ~scl_q & scl_prev;
  assign start_det = scl_q & scl_prev & sda_prev & ~sda;
  assign stop_det  = scl_q & scl_prev & ~sda_prev & sda;

endmodule

// File: rtl/smbus_target_fsm.sv
module smbus_target_fsm
  import cfg_smbus_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h6D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  input  logic [7:0] cnt_byte,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_data
);
  tgt_state_e st, st_n, ret, ret_n;
  logic [7:0] sh, sh_n, tx, tx_n, rem, rem_n, ptr_n;
  logic [3:0] bitc, bitc_n;
  logic       oe_n, hack, hack_n;

  always_comb begin
    st_n = st; ret_n = ret; sh_n = sh; tx_n = tx; rem_n = rem;
    ptr_n = ptr; bitc_n = bitc; oe_n = sda_oe; hack_n = hack;
    wr_en = 1'b0;
    if (start_det) begin
      st_n = ST_ADDR; bitc_n = 4'd0; oe_n = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE; bitc_n = 4'd0; oe_n = 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_OFFS, ST_CNT, ST_WDATA: begin
          if (scl_rise) begin
            sh_n   = {sh[6:0], sda};
            bitc_n = bitc + 4'd1;
          end else if (scl_fall && bitc == 4'd8) begin
            bitc_n = 4'd0;
            st_n   = ST_ACK;
            oe_n   = 1'b1;
            case (st)
              ST_ADDR: begin
                if (sh[7:1] != TARGET_ADDR) begin
                  st_n = ST_WAIT; oe_n = 1'b0;
                end else begin
                  ret_n = sh[0] ? ST_TX : ST_OFFS;
                end
              end
              ST_OFFS: begin ptr_n = sh; ret_n = ST_CNT; end
              ST_CNT:  begin rem_n = sh; ret_n = ST_WDATA; end
              default: begin
                ret_n = ST_WDATA;
                if (rem != 8'd0) begin
                  wr_en = 1'b1;
                  ptr_n = ptr + 8'd1;
                  rem_n = rem - 8'd1;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            st_n = ret;
            oe_n = 1'b0;
            if (ret == ST_TX) begin
              tx_n = cnt_byte;
              oe_n = ~cnt_byte[7];
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitc_n = bitc + 4'd1;
          end else if (scl_fall) begin
            if (bitc == 4'd8) begin
              bitc_n = 4'd0; oe_n = 1'b0; st_n = ST_HACK;
            end else begin
              tx_n = {tx[6:0], 1'b0};
              oe_n = ~tx[6];
            end
          end
        end
        ST_HACK: begin
          if (scl_rise) begin
            hack_n = ~sda;
          end else if (scl_fall) begin
            if (hack) begin
              st_n  = ST_TX;
              tx_n  = rd_data;
              oe_n  = ~rd_data[7];
              ptr_n = ptr + 8'd1;
            end else begin
              st_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ret <= ST_IDLE; sh <= '0; tx <= '0; rem <= '0;
      ptr <= '0; bitc <= '0; sda_oe <= 1'b0; hack <= 1'b0;
    end else begin
      st <= st_n; ret <= ret_n; sh <= sh_n; tx <= tx_n; rem <= rem_n;
      ptr <= ptr_n; bitc <= bitc_n; sda_oe <= oe_n; hack <= hack_n;
    end
  end

  assign wr_data = sh;

  assert_start_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR && !sda_oe));
  assert_release_when_parked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT || st == ST_IDLE) |-> !sda_oe);
  assert_index_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == $past(ptr) + 8'd1);
  assert_no_write_past_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rem == 8'd0) |-> !wr_en);

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_smbus_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      idx,
  input  logic [7:0]      wr_data,
  input  logic [1:0]      mode_pins,
  output logic [7:0]      rd_data,
  output logic [7:0]      cnt_byte,
  output logic [3:0][7:0] ctl
);
  localparam int IW = $clog2(NREG);
  localparam logic [7:0] NREG_B = 8'(NREG);

  logic [NREG-1:0][7:0] store, view;
  logic [1:0] rb;
  logic       rb_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) store[i] <= reg_rstval(i) & reg_wmask(i);
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (idx == 8'(i)) store[i] <= wr_data & reg_wmask(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb <= 2'b00; rb_done <= 1'b0;
    end else if (!rb_done) begin
      rb <= mode_pins; rb_done <= 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NREG; i++)
      view[i] = (store[i] & reg_wmask(i)) | (reg_fixed(i) & ~reg_wmask(i));
    view[MODE_IDX][7:6] = rb;
  end

  assign rd_data  = (idx < NREG_B) ? view[idx[IW-1:0]] : 8'hFF;
  assign cnt_byte = view[CNT_IDX];

  generate
    for (genvar g = 0; g < 4; g++) begin : g_ctl
      assign ctl[g] = view[g];
    end
  endgenerate

  assert_count_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 8'(CNT_IDX)) |=> cnt_byte == {3'b000, $past(wr_data[4:0])});
  assert_strap_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rb_done |=> $stable(rb));

endmodule

// File: rtl/cfg_smbus_target.sv
module cfg_smbus_target #(
  parameter int         SYNC_STAGES = 2,
  parameter int         NREG        = 8,
  parameter logic [6:0] TARGET_ADDR = 7'h6D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       hw_oe_i,
  input  logic [1:0] mode_pins_i,
  output logic       sda_oe_o,
  output logic [1:0] out_en_o,
  output logic [1:0] slew_fast_o,
  output logic       fb_slew_fast_o,
  output logic [1:0] amp_o,
  output logic [1:0] mode_o,
  output logic [1:0] freq_o
);
  logic [1:0] rst_pipe;
  logic       srst_n;
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] ptr, wr_data, rd_data, cnt_byte;
  logic [3:0][7:0] ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  smbus_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(srst_n), .scl_i(scl_i), .sda_i(sda_i), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  smbus_target_fsm #(.TARGET_ADDR(TARGET_ADDR)) i_fsm (
    .clk(clk), .rst_n(srst_n), .sda(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .cnt_byte(cnt_byte), .sda_oe(sda_oe_o), .ptr(ptr),
    .wr_en(wr_en), .wr_data(wr_data));

  cfg_reg_bank #(.NREG(NREG)) i_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .idx(ptr), .wr_data(wr_data),
    .mode_pins(mode_pins_i), .rd_data(rd_data), .cnt_byte(cnt_byte), .ctl(ctl));

  assign out_en_o       = {hw_oe_i & ctl[0][5], hw_oe_i & ctl[0][3]};
  assign slew_fast_o    = {ctl[2][5], ctl[2][3]};
  assign fb_slew_fast_o = ctl[3][0];
  assign amp_o          = ctl[1][1:0];
  assign mode_o         = ctl[1][5] ? ctl[1][4:3] : ctl[1][7:6];
  assign freq_o         = ctl[3][5] ? ctl[3][4:3] : 2'b00;

  assert_pin_gates_outputs_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !hw_oe_i |-> out_en_o == 2'b00);
  assert_mode_follows_strap_R9: assert property (@(posedge clk) disable iff (!srst_n)
    !ctl[1][5] |-> mode_o == ctl[1][7:6]);
  assert_freq_gated_R10: assert property (@(posedge clk) disable iff (!srst_n)
    !ctl[3][5] |-> freq_o == 2'b00);

endmodule

// File: tb/test_cfg_smbus_target.sv
module test_cfg_smbus_target;
  localparam int H = 20;
  localparam logic [6:0] DEV = 7'b1101101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic h_low = 1'b0;
  logic hw_oe = 1'b1;
  logic [1:0] pins = 2'b01;
  logic [1:0] pins_l = 2'b01;
  logic sda_oe, fb_slew;
  logic [1:0] out_en, slew, amp, mode, freq;
  wire  sda_line = ~(h_low | sda_oe);

  always #5 clk = ~clk;

  cfg_smbus_target i_cfg_smbus_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .hw_oe_i(hw_oe),
    .mode_pins_i(pins), .sda_oe_o(sda_oe), .out_en_o(out_en),
    .slew_fast_o(slew), .fb_slew_fast_o(fb_slew), .amp_o(amp),
    .mode_o(mode), .freq_o(freq));

  int n_chk = 0;
  int n_fail = 0;
  int win_bad = 0;
  logic quiet = 1'b0;
  logic [7:0] m [8];

  function automatic logic [7:0] exp_rd(input int i);
    case (i)
      0:       return m[0] | 8'hD7;
      1:       return {pins_l, m[1][5:0] | 6'h04};
      2:       return m[2] | 8'hD7;
      3:       return m[3] | 8'hC6;
      5:       return 8'h01;
      6:       return 8'h42;
      7:       return {3'b000, m[7][4:0]};
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [11:0] exp_out();
    logic [1:0] md, fq;
    md = m[1][5] ? m[1][4:3] : pins_l;
    fq = m[3][5] ? m[3][4:3] : 2'b00;
    return {hw_oe & m[0][5], hw_oe & m[0][3], m[2][5], m[2][3], m[3][0],
            m[1][1:0], md, fq, 1'b0};
  endfunction

  wire [11:0] got_out = {out_en, slew, fb_slew, amp, mode, freq, sda_oe};

  always @(negedge clk) if (quiet && got_out !== exp_out()) win_bad++;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic open_quiet();
    repeat (6) @(negedge clk);
    win_bad = 0;
    quiet = 1'b1;
  endtask

  task automatic close_quiet(input string req);
    if (quiet) begin
      quiet = 1'b0;
      chk(req, "outputs vs model between transfers", 32'(win_bad), 32'd0);
    end
  endtask

  task automatic model_write(input int i, input logic [7:0] v);
    case (i)
      0, 2: m[i] = v & 8'h28;
      1:    m[i] = v & 8'h3B;
      3:    m[i] = v & 8'h39;
      7:    m[i] = v & 8'h1F;
      default: ;
    endcase
  endtask

  task automatic do_reset(input logic [1:0] p);
    quiet = 1'b0;
    rst_n = 1'b0; scl = 1'b1; h_low = 1'b0;
    pins = p; pins_l = p;
    m[0] = 8'h28; m[1] = 8'h02; m[2] = 8'h28; m[3] = 8'h01; m[7] = 8'h08;
    m[4] = 8'h00; m[5] = 8'h00; m[6] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    open_quiet();
  endtask

  task automatic hw(); repeat (H) @(negedge clk); endtask
  task automatic q4(); repeat (4) @(negedge clk); endtask

  task automatic bus_start();
    h_low = 1'b0; hw(); scl = 1'b1; hw(); h_low = 1'b1; hw(); scl = 1'b0; q4();
  endtask

  task automatic bus_stop();
    h_low = 1'b1; hw(); scl = 1'b1; hw(); h_low = 1'b0; hw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      h_low = ~b[i]; hw(); scl = 1'b1; hw(); scl = 1'b0; q4();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    h_low = 1'b0; hw(); scl = 1'b1; hw();
    ack = (sda_line == 1'b0);
    scl = 1'b0; q4();
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] b);
    b = 8'h00;
    h_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      hw(); scl = 1'b1; hw();
      b = {b[6:0], sda_line};
      scl = 1'b0; q4();
    end
    h_low = ack_it; hw(); scl = 1'b1; hw(); scl = 1'b0; q4();
    h_low = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] n, input logic [7:0] x,
                          input logic [7:0] d [4], input int nd, input string req);
    logic a, all_ack;
    close_quiet(req);
    bus_start();
    send_byte({DEV, 1'b0}, a); all_ack = a;
    send_byte(n, a); all_ack &= a;
    send_byte(x, a); all_ack &= a;
    for (int k = 0; k < nd; k++) begin
      send_byte(d[k], a); all_ack &= a;
    end
    bus_stop();
    chk(req, "every write byte acknowledged", 32'(all_ack), 32'd1);
    for (int k = 0; k < nd; k++)
      if (k < int'(x)) model_write(int'(n) + k, d[k]);
    open_quiet();
  endtask

  task automatic do_read(input logic [7:0] n, input int nb, input string req);
    logic a;
    logic [7:0] b;
    close_quiet(req);
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(n, a);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk("R1", "read address acknowledged", 32'(a), 32'd1);
    recv_byte(1'b1, b);
    chk("R4", "count byte", 32'(b), 32'(exp_rd(7)));
    for (int k = 0; k < nb; k++) begin
      recv_byte(k != nb - 1, b);
      chk(req, $sformatf("read byte at index %0d", int'(n) + k), 32'(b),
          32'(exp_rd(int'(n) + k)));
    end
    hw();
    chk("R4", "SDA released after host NACK", 32'(sda_oe), 32'd0);
    bus_stop();
    open_quiet();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R11 watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic a;
    do_reset(2'b01);
    // R6 R12: reset outputs and idle SDA
    close_quiet("R6 R12");
    chk("R6", "reset out_en", 32'(out_en), 32'd3);
    chk("R12", "idle SDA drive", 32'(sda_oe), 32'd0);
    open_quiet();
    // R5 R6 R7 R9: full readback after reset, one index past the end
    do_read(8'd0, 9, "R6");

    // R2 R10: write regs 1..3 with exact count
    do_write(8'd1, 8'd3, '{8'h39, 8'h00, 8'h3E, 8'h00}, 3, "R2");
    close_quiet("R10");
    chk("R10", "amplitude", 32'(amp), 32'd1);
    chk("R10", "frequency select enabled", 32'(freq), 32'd3);
    chk("R9", "mode from register", 32'(mode), 32'd3);
    chk("R10", "slew selects", 32'({slew, fb_slew}), 32'd0);
    open_quiet();
    do_read(8'd1, 3, "R2");

    // R8: hardware pin low gates both enables
    close_quiet("R8");
    hw_oe = 1'b0;
    open_quiet();
    repeat (30) @(negedge clk);
    chk("R8", "enables with pin low", 32'(out_en), 32'd0);
    close_quiet("R8");
    hw_oe = 1'b1;
    open_quiet();

    // R3: bytes beyond count discarded
    do_write(8'd0, 8'd1, '{8'h00, 8'h55, 8'hAA, 8'h00}, 3, "R3");
    chk("R8", "enables cleared by register", 32'(out_en), 32'd0);
    do_read(8'd0, 3, "R3");

    // R7 R5: read-only span and count register
    do_write(8'd4, 8'd5, '{8'h00, 8'h00, 8'h00, 8'hE3}, 4, "R7");
    do_read(8'd5, 4, "R7");
    do_write(8'd8, 8'd2, '{8'h12, 8'h34, 8'h00, 8'h00}, 2, "R7");
    do_read(8'd6, 3, "R5");

    // R1: foreign address
    close_quiet("R1");
    bus_start();
    send_byte(8'hA0, a);
    chk("R1", "foreign address not acknowledged", 32'(a), 32'd0);
    send_byte(8'h00, a);
    chk("R1", "bytes after foreign address not acknowledged", 32'(a), 32'd0);
    send_byte(8'h01, a);
    send_byte(8'h28, a);
    bus_stop();
    open_quiet();
    do_read(8'd0, 1, "R1");

    // R11: start inside a data byte aborts without write
    close_quiet("R11");
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'd0, a);
    send_byte(8'd1, a);
    send_bits(8'hFF, 5);
    bus_start();
    send_byte({DEV, 1'b0}, a);
    chk("R11", "address accepted after mid-byte start", 32'(a), 32'd1);
    bus_stop();
    open_quiet();
    do_read(8'd0, 1, "R11");

    // R9 R10: fields ignored while their enables are clear
    do_write(8'd1, 8'd3, '{8'h18, 8'h28, 8'h18, 8'h00}, 3, "R10");
    close_quiet("R9");
    chk("R9", "mode falls back to strap", 32'(mode), 32'd1);
    chk("R10", "frequency gated off", 32'(freq), 32'd0);
    open_quiet();

    // R9 R6: new reset with different straps
    close_quiet("R9");
    do_reset(2'b10);
    do_read(8'd1, 1, "R9");
    chk("R9", "mode after second reset", 32'(mode), 32'd2);
    close_quiet("R12");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule